// File: doc/BRIEF.md
# Serial-Commanded Four-Channel Output Switch Controller

This block is the digital core of a four-channel low-side switch. A host commands it through an SPI slave port (active-low select, serial clock, data in, data out) in mode 0. Each output is the OR of a latched serial command bit and a dedicated parallel pin, so a host can run pulse-width modulation on the pins without sending a serial frame for every edge. The port signals are oversampled by the block's own clock through two-flop synchronizers, and their edges are detected inside that clock domain.

Each channel reports two digital fault flags. One covers faults that only matter while the channel conducts (overcurrent, short to the supply). The other covers faults that only matter while it is off (open load, short to ground). Each flag is qualified by the channel's actual output state. A qualified fault is held in a sticky register until the next select fall. At that fall the sticky word is copied into the shift register, so the host reads it out while it clocks the next command in. Frames of 8 bits carry a plain command. In a 16-bit frame the first byte sent is echoed back in the second half of the frame, which lets the host verify its command.

Top module: `quad_switch_ctrl`

## Requirements
- R1: While `cs_n` is high, activity on `sclk` and `mosi` has no effect: the command latch and the outputs keep their values, and `miso` is driven low.
- R2: Data moves MSB first. `mosi` is sampled on the rising `sclk` edge. `miso` changes only after a falling `sclk` edge, so it holds its value across each rising edge and the high phase that follows.
- R3: On a rising edge of `cs_n`, the last four bits received load the command latch. The fourth-last bit received controls channel 3 and the last bit received controls channel 0.
- R4: `drv_out[i]` is the OR of command bit i and `par_in[i]`.
- R5: After a falling edge of `cs_n`, the first four bits on `miso` are the sticky faults for channel 3 down to channel 0. The next four bits are zero.
- R6: `flt_on[i]` is recorded only while `drv_out[i]` is 1. `flt_off[i]` is recorded only while `drv_out[i]` is 0.
- R7: A qualified fault that lasts one clock cycle or longer is reported in the next frame. A fault that has been captured is cleared, so a later frame reports only faults that occurred after the previous `cs_n` fall.
- R8: In a 16-bit frame, bits 9 to 16 on `miso` repeat bits 1 to 8 sent on `mosi`, and the last four bits sent set the command latch.
- R9: A synchronous active-low reset clears the command latch, the sticky faults and the shift register, so `drv_out` equals `par_in` and the next frame reports no faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, low while deselected |
| par_in | input | 4 | Parallel on-request per channel |
| flt_on | input | 4 | On-state fault flags per channel |
| flt_off | input | 4 | Off-state fault flags per channel |
| drv_out | output | 4 | Channel drive, 1 = switch on |

## Verification
A port edge goes through two synchronizer flops and one edge-detect flop, and its effect is registered on the third clock edge after the change. The command latch therefore settles three cycles after `cs_n` rises, the fault word is loaded three cycles after `cs_n` falls, and `miso` moves three cycles after `sclk` falls. `drv_out` follows `par_in` in the same cycle, and a fault flag reaches the sticky register on the next edge. The bench holds each serial phase for six clocks and waits eight clocks after deselect before it samples, so every sample falls after the result is due. Fault flags are pulsed only while the outputs are steady and no select edge is pending, which keeps the bench's fault model cycle-exact.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
  localparam int DEF_NCH   = 4;
  localparam int DEF_FRAME = 8;
  localparam int SYNC_LEN  = 2;

  // A fault flag counts only in the output state it belongs to.
  function automatic logic [31:0] qualify_faults(input logic [31:0] out_on,
                                                 input logic [31:0] f_on,
                                                 input logic [31:0] f_off);
    return (out_on & f_on) | (~out_on & f_off);
  endfunction

  // Rising and falling edge pulses from a synchronized level and its last value.
  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic edge_down(input logic now_v, input logic prev_v);
    return ~now_v & prev_v;
  endfunction
endpackage

// File: rtl/qsw_sync.sv
module qsw_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_sync,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= {STAGES{RST_VAL}};
      q_prev <= RST_VAL;
    end else begin
      chain  <= {chain[STAGES-2:0], d_in};
      q_prev <= chain[STAGES-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/qsw_fault.sv
module qsw_fault
  import qsw_pkg::*;
#(
  parameter int NCH = DEF_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] out_state,
  input  logic [NCH-1:0] flt_on,
  input  logic [NCH-1:0] flt_off,
  input  logic           capture,
  output logic [NCH-1:0] flt_word
);
  logic [NCH-1:0] sticky;
  logic [NCH-1:0] set_now;
  logic [31:0]    qual_full;

  assign qual_full = qualify_faults(32'(out_state), 32'(flt_on), 32'(flt_off));
  assign set_now   = qual_full[NCH-1:0];
  assign flt_word  = sticky | set_now;

  always_ff @(posedge clk) begin
    if (!rst_n)       sticky <= '0;
    else if (capture) sticky <= '0;
    else              sticky <= sticky | set_now;
  end

  assert_sticky_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ((sticky & $past(set_now)) == $past(set_now)));

  assert_capture_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sticky == '0));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (sticky == '0));
endmodule

// File: rtl/qsw_shift.sv
module qsw_shift
  import qsw_pkg::*;
#(
  parameter int NCH   = DEF_NCH,
  parameter int FRAME = DEF_FRAME
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_act,
  input  logic           cs_fall,
  input  logic           sclk_rise,
  input  logic           sclk_fall,
  input  logic           mosi_s,
  input  logic [NCH-1:0] flt_word,
  output logic           miso,
  output logic [NCH-1:0] cmd_bits
);
  localparam int PAD = FRAME - NCH;

  logic [FRAME-1:0] sr;
  logic             in_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr     <= '0;
      in_bit <= 1'b0;
    end else if (cs_fall) begin
      sr <= {flt_word, {PAD{1'b0}}};
    end else if (cs_act) begin
      if (sclk_rise) in_bit <= mosi_s;
      if (sclk_fall) sr     <= {sr[FRAME-2:0], in_bit};
    end
  end

  assign miso     = cs_act & sr[FRAME-1];
  assign cmd_bits = sr[NCH-1:0];

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> $stable(sr));

  assert_load_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sr[PAD-1:0] == '0));

  assert_rise_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_fall && !sclk_fall) |=> $stable(sr));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> (sr == '0));
endmodule

// File: rtl/quad_switch_ctrl.sv
module quad_switch_ctrl
  import qsw_pkg::*;
#(
  parameter int NCH   = DEF_NCH,
  parameter int FRAME = DEF_FRAME
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic           mosi,
  output logic           miso,
  input  logic [NCH-1:0] par_in,
  input  logic [NCH-1:0] flt_on,
  input  logic [NCH-1:0] flt_off,
  output logic [NCH-1:0] drv_out
);
  logic cs_s, cs_p, sclk_s, sclk_p, mosi_s, mosi_p;
  logic cs_act, cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [NCH-1:0] cmd_q;
  logic [NCH-1:0] cmd_bits;
  logic [NCH-1:0] flt_word;

  qsw_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d_in(cs_n), .q_sync(cs_s), .q_prev(cs_p));
  qsw_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_in(sclk), .q_sync(sclk_s), .q_prev(sclk_p));
  qsw_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d_in(mosi), .q_sync(mosi_s), .q_prev(mosi_p));

  // Named event wires used by the logic and the assertions.
  assign cs_act    = ~cs_s;
  assign cs_fall   = edge_down(cs_s, cs_p);
  assign cs_rise   = edge_up(cs_s, cs_p);
  assign sclk_rise = edge_up(sclk_s, sclk_p);
  assign sclk_fall = edge_down(sclk_s, sclk_p);

  qsw_fault #(.NCH(NCH)) u_fault (
    .clk(clk), .rst_n(rst_n), .out_state(drv_out), .flt_on(flt_on),
    .flt_off(flt_off), .capture(cs_fall), .flt_word(flt_word));

  qsw_shift #(.NCH(NCH), .FRAME(FRAME)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .flt_word(flt_word), .miso(miso), .cmd_bits(cmd_bits));

  always_ff @(posedge clk) begin
    if (!rst_n)       cmd_q <= '0;
    else if (cs_rise) cmd_q <= cmd_bits;
  end

  assign drv_out = cmd_q | par_in;

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cmd_q));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> (miso == 1'b0));

  assert_reset_cmd_R9: assert property (@(posedge clk)
    !rst_n |=> (cmd_q == '0));

  assert_par_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_out & par_in) == par_in));

  logic unused_mosi_prev;
  assign unused_mosi_prev = mosi_p;
endmodule

// File: tb/quad_switch_ctrl_bench.sv
module quad_switch_ctrl_bench;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic [3:0] par_in = 4'h0;
  logic [3:0] flt_on = 4'h0;
  logic [3:0] flt_off = 4'h0;
  logic [3:0] drv_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0] m_cmd = 4'h0;
  logic [3:0] m_sticky = 4'h0;
  logic       m_clr = 1'b0;

  always #2 clk = ~clk;

  quad_switch_ctrl u_quad_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .par_in(par_in), .flt_on(flt_on), .flt_off(flt_off),
    .drv_out(drv_out));

  function automatic logic [3:0] exp_drive(input logic [3:0] c, input logic [3:0] p);
    return c | p;
  endfunction

  function automatic logic [3:0] exp_fault(input logic [3:0] st, input logic [3:0] a,
                                           input logic [3:0] b);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = st[i] ? a[i] : b[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n)     m_sticky <= 4'h0;
    else if (m_clr) m_sticky <= 4'h0;
    else            m_sticky <= m_sticky | exp_fault(exp_drive(m_cmd, par_in), flt_on, flt_off);
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [15:0] din, output logic [15:0] dout,
                      output logic [3:0] flt_exp, output bit order_ok);
    logic b;
    dout = '0;
    order_ok = 1'b1;
    @(negedge clk);
    flt_exp = m_sticky;
    cs_n = 1'b0;
    m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = din[i];
      repeat (HALF) @(negedge clk);
      b = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== b) order_ok = 1'b0;
      sclk = 1'b0;
      dout[i] = b;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    m_cmd = din[3:0];
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_faults(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    flt_on = a;
    flt_off = b;
    @(negedge clk);
    flt_on = 4'h0;
    flt_off = 4'h0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d, o;
    logic [3:0]  fe;
    bit          ok;
    void'($urandom(32'h5EED_0C1A));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset outputs", {12'h0, drv_out}, 16'h0);
    chk("R1 miso idle", {15'h0, miso}, 16'h0);

    // R6 directed: off channel ignores on-state flags, records off-state flags
    pulse_faults(4'hF, 4'h0);
    xfer(8, 16'h0000, o, fe, ok);
    chk("R6 on-flag ignored while off", o[7:0], 16'h0000);
    pulse_faults(4'h0, 4'h5);
    xfer(8, 16'h000F, o, fe, ok);
    chk("R5 fault word ch3..ch0 then zeros", o[7:0], {8'h0, 4'h5, 4'h0});
    chk("R3 command latch", {12'h0, drv_out}, 16'h000F);
    pulse_faults(4'h0, 4'hF);
    pulse_faults(4'h9, 4'h0);
    xfer(8, 16'h0003, o, fe, ok);
    chk("R6 on-state flags only when on", o[7:0], 16'h0090);
    xfer(8, 16'h0003, o, fe, ok);
    chk("R7 cleared after capture", o[7:0], 16'h0000);

    // R1: sclk and mosi toggling while deselected
    for (int k = 0; k < 8; k++) begin
      mosi = k[0];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (miso !== 1'b0) chk("R1 miso low while deselected", {15'h0, miso}, 16'h0);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R1 outputs unchanged", {12'h0, drv_out}, 16'h0003);

    // R4: parallel pins ORed
    par_in = 4'hC;
    @(negedge clk);
    chk("R4 parallel OR", {12'h0, drv_out}, 16'h000F);
    par_in = 4'h0;
    @(negedge clk);

    // random frames
    for (int it = 0; it < 40; it++) begin
      logic [3:0] fa, fb;
      int n;
      fa = 4'($urandom);
      fb = 4'($urandom);
      par_in = 4'($urandom) & 4'($urandom);
      @(negedge clk);
      pulse_faults(fa, fb);
      d = 16'($urandom);
      n = (it % 3 == 0) ? 16 : 8;
      xfer(n, d, o, fe, ok);
      chk("R2 miso stable through rising edge", {15'h0, ok}, 16'h1);
      if (n == 16) begin
        chk("R8 fault byte first", {8'h0, o[15:8]}, {8'h0, fe, 4'h0});
        chk("R8 echo of first byte", {8'h0, o[7:0]}, {8'h0, d[15:8]});
      end else begin
        chk("R7 sticky fault report", {8'h0, o[7:0]}, {8'h0, fe, 4'h0});
      end
      chk("R3 R4 drive after frame", {12'h0, drv_out}, {12'h0, exp_drive(d[3:0], par_in)});
    end
    par_in = 4'h0;

    // R9: reset mid-run with pending faults
    xfer(8, 16'h000A, o, fe, ok);
    pulse_faults(4'hA, 4'h5);
    @(negedge clk);
    rst_n = 1'b0;
    m_cmd = 4'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    par_in = 4'h2;
    repeat (3) @(negedge clk);
    chk("R9 drive equals par after reset", {12'h0, drv_out}, 16'h0002);
    xfer(8, 16'h0000, o, fe, ok);
    chk("R9 no faults after reset", o[7:0], 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule